// File: doc/BRIEF.md
# Serial Host Control and Status Port

This block is the host-facing control port of an audio receiver. A host drives a three-wire serial link (an enable line, a bit clock and a data line) and the block answers on a fourth, data-out line. Each transfer opens with an 8-bit address. One address code makes the transfer a write, and the next 16 bits then form a mode word. A second address code makes it a read, and the block shifts out a 16-bit status word. Every other address leaves the block untouched.

The mode word is decoded into the receiver's static settings: which input the demodulator listens to, what each of two monitor outputs carries, whether audio words are 16 or 20 bits long, and a global stop. Three of the eight input-select codes do not pick an input. They put the receiver into analog-source mode, in which it runs from the crystal clock.

The status word packs the sampling-frequency code, the copy flag, the first channel-status bit and the 8-bit category code. The demodulator loads these fields with a strobe. While lock is lost or analog-source mode is active, the status word is held at a fixed error pattern, and that same pattern is present from reset until the first strobe. The serial inputs are synchronised into the system clock and sampled on the rising edge of the serial clock.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset every decoded output (`src_sel`, `mon1_sel`, `mon2_sel`, `word20`, `sys_stop`, `analog_mode`) is 0 and `host_sdo` is 0.
- R2: A transfer consisting of the write address (bits in arrival order 1,0,1,0,0,1,1,0) followed by exactly 16 data bits, then enable low, updates the mode outputs. Data bits arrive I0 first. The fields are `sys_stop`=I4, `src_sel`=I7..I5 (I5 least significant), `mon1_sel`=I10..I8, `mon2_sel`=I13..I11 and `word20`=I14. Bits I0..I3 and I15 have no effect.
- R3: `analog_mode` is 1 exactly when the committed `src_sel` code is 5, 6 or 7.
- R4: A transfer whose address matches neither code leaves every mode output unchanged. A 16-bit data phase sent after the read address also leaves every mode output unchanged.
- R5: A write whose data phase has 15 bits, or 17 bits, leaves every mode output unchanged.
- R6: After the read address (arrival order 0,1,1,0,0,1,1,0), `host_sdo` presents status bit D0 first and advances one bit per further serial-clock rise. The status bits are laid out as follows:
  - D1 = `st_fs[1]`
  - D2 = `st_fs[0]`
  - D3 = `st_copy`
  - D4 = `st_cs0`
  - D12..D5 = `st_cat[7:0]`, with D5 = `st_cat[0]`

  The status fields are taken from the values latched at the last `st_valid` pulse.
- R7: While `lock_ok` is 0, the status word reads D1=1 and every other bit 0. The latched fields are discarded, so they read as this pattern until a new `st_valid` pulse arrives with lock present.
- R8: While `analog_mode` is 1, the status word reads the same error pattern as in R7.
- R9: From reset until the first `st_valid` pulse, a read returns the error pattern even when `lock_ok` is 1.
- R10: D0 and D13..D15 always read 0. Read bits clocked beyond the 16th read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce | input | 1 | Serial enable, high during a transfer |
| host_sck | input | 1 | Serial bit clock, sampled on rising edge |
| host_sdi | input | 1 | Serial data from host |
| host_sdo | output | 1 | Serial read data to host |
| lock_ok | input | 1 | Demodulator lock indication |
| st_valid | input | 1 | Strobe that latches the status fields |
| st_fs | input | 2 | Sampling-frequency code: [1] is D1, [0] is D2 |
| st_copy | input | 1 | Copy flag, 1 means copying is allowed |
| st_cs0 | input | 1 | First channel-status bit |
| st_cat | input | 8 | Category code |
| src_sel | output | 3 | Demodulator input select code |
| mon1_sel | output | 3 | First monitor output select |
| mon2_sel | output | 3 | Second monitor output select |
| word20 | output | 1 | 1 selects 20-bit audio words, 0 selects 16-bit |
| sys_stop | output | 1 | Global stop request |
| analog_mode | output | 1 | Analog-source mode active |

## Verification
Writes are sent with field values chosen so that every field sits at a different code and the unused bits carry ones. This exposes swapped or shifted fields as well as leakage from the unused bits. Writes with an unknown address, with the read address, and with 15 or 17 data bits must leave a known setting intact, which separates address matching from length checking. Reads are issued with an asymmetric category code and mixed flags, which exposes bit-order errors. Further reads are taken before any strobe, with lock lost, and in each analog code, which tells the forced pattern apart from stale latched data. A read with 20 clocks probes the trailing zero fill.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int SYNC_STAGES = 2;
  localparam int SEL_W = 3;
  localparam int CAT_W = 8;

  // Address codes, first arriving bit in bit 0
  localparam logic [ADDR_W-1:0] ADDR_WR = 8'h65;
  localparam logic [ADDR_W-1:0] ADDR_RD = 8'h66;

  // Status pattern during lock loss / analog source
  localparam logic [DATA_W-1:0] STAT_FORCED = 16'h0002;

  localparam logic [SEL_W-1:0] SRC_ANALOG_MIN = 3'd5;

  typedef struct packed {
    logic             word20;
    logic [SEL_W-1:0] mon2;
    logic [SEL_W-1:0] mon1;
    logic [SEL_W-1:0] src;
    logic             stop;
  } mode_t;
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ser_ctl_frame.sv
module ser_ctl_frame
  import ser_ctl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          sck,
  input  logic          sdi,
  input  logic [DW-1:0] stat_word,
  output logic          sdo,
  output logic          commit,
  output logic [DW-1:0] wdata
);
  localparam int CNT_MAX_I = AW + DW + 1;
  localparam int CNT_W = $clog2(CNT_MAX_I + 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(CNT_MAX_I);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(AW - 1);
  localparam logic [CNT_W-1:0] ADDR_LEN  = CNT_W'(AW);
  localparam logic [CNT_W-1:0] FRAME_LEN = CNT_W'(AW + DW);

  logic             sck_q, ce_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [DW-1:0]    dat_q, dat_d;
  logic [DW-1:0]    rsh_q, rsh_d;
  logic             ract_q, ract_d;
  logic             whit_q, whit_d;
  logic             rise;

  assign rise = sck & ~sck_q;

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    dat_d  = dat_q;
    rsh_d  = rsh_q;
    ract_d = ract_q;
    whit_d = whit_q;
    if (!ce) begin
      cnt_d  = '0;
      ract_d = 1'b0;
      whit_d = 1'b0;
    end else if (rise) begin
      if (cnt_q < ADDR_LEN) addr_d = {sdi, addr_q[AW-1:1]};
      else                  dat_d  = {sdi, dat_q[DW-1:1]};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (cnt_q == ADDR_LAST) begin
        whit_d = (addr_d == ADDR_WR);
        ract_d = (addr_d == ADDR_RD);
        rsh_d  = stat_word;
      end else if (ract_q) begin
        rsh_d = {1'b0, rsh_q[DW-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      ce_q   <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      dat_q  <= '0;
      rsh_q  <= '0;
      ract_q <= 1'b0;
      whit_q <= 1'b0;
    end else begin
      sck_q  <= sck;
      ce_q   <= ce;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      dat_q  <= dat_d;
      rsh_q  <= rsh_d;
      ract_q <= ract_d;
      whit_q <= whit_d;
    end
  end

  assign commit = ce_q & ~ce & whit_q & (cnt_q == FRAME_LEN);
  assign wdata  = dat_q;
  assign sdo    = ract_q & rsh_q[0];

  // R6: the read shifter captures the status word seen at the last address bit
  a_r6_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && rise && cnt_q == ADDR_LAST && addr_d == ADDR_RD) |=> (rsh_q == $past(stat_word)));

  // R4: no read phase starts while the address is still arriving
  a_r4_no_early_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && cnt_q < ADDR_LAST) |=> !ract_q);

  // R10: once the read shifter has been emptied, sdo stays low for the rest of the transfer
  a_r10_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ract_q && rsh_q == '0 && ce) |=> !sdo);
endmodule

// File: rtl/ser_ctl_mode.sv
module ser_ctl_mode
  import ser_ctl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [DW-1:0] wdata,
  output mode_t         mode,
  output logic          analog
);
  mode_t mode_q, mode_d;
  logic  unused_bits;

  assign unused_bits = ^{wdata[3:0], wdata[DW-1]};

  always_comb begin
    mode_d = mode_q;
    if (commit) begin
      mode_d.stop   = wdata[4];
      mode_d.src    = wdata[7:5];
      mode_d.mon1   = wdata[10:8];
      mode_d.mon2   = wdata[13:11];
      mode_d.word20 = wdata[14];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign mode   = mode_q;
  assign analog = (mode_q.src >= SRC_ANALOG_MIN);

  // R2/R4/R5: settings change only after a commit
  a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(mode_q));

  // R3: analog mode follows the committed source code
  a_r3_analog_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wdata[7:5] >= SRC_ANALOG_MIN) |=> analog);
endmodule

// File: rtl/ser_ctl_status.sv
module ser_ctl_status
  import ser_ctl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_ok,
  input  logic          analog,
  input  logic          st_valid,
  input  logic [1:0]    st_fs,
  input  logic          st_copy,
  input  logic          st_cs0,
  input  logic [CW-1:0] st_cat,
  output logic [DW-1:0] word
);
  localparam int PAD_W = DW - CW - 5;

  logic [DW-1:0] stat_q, stat_d;
  logic [DW-1:0] packed_w;
  logic          forced;

  assign forced   = ~lock_ok | analog;
  assign packed_w = {{PAD_W{1'b0}}, st_cat, st_cs0, st_copy, st_fs[0], st_fs[1], 1'b0};

  always_comb begin
    stat_d = stat_q;
    if (forced)        stat_d = STAT_FORCED;
    else if (st_valid) stat_d = packed_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_FORCED;
    else        stat_q <= stat_d;
  end

  assign word = stat_q;

  a_r7_forced_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ok |=> (stat_q == STAT_FORCED));

  a_r8_forced_in_analog: assert property (@(posedge clk) disable iff (!rst_n)
    analog |=> (stat_q == STAT_FORCED));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] == 1'b0) && (stat_q[DW-1:CW+5] == '0));

  a_r9_hold_until_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && !forced) |=> $stable(stat_q));
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ser_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_ce,
  input  logic       host_sck,
  input  logic       host_sdi,
  output logic       host_sdo,
  input  logic       lock_ok,
  input  logic       st_valid,
  input  logic [1:0] st_fs,
  input  logic       st_copy,
  input  logic       st_cs0,
  input  logic [7:0] st_cat,
  output logic [2:0] src_sel,
  output logic [2:0] mon1_sel,
  output logic [2:0] mon2_sel,
  output logic       word20,
  output logic       sys_stop,
  output logic       analog_mode
);
  logic [1:0]        rst_sh;
  logic              rst_i;
  logic [2:0]        pins_s;
  logic              commit;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] stat_word;
  mode_t             mode;
  logic              analog;

  // reset asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_i = rst_sh[1];

  ser_ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({host_ce, host_sck, host_sdi}),
    .q     (pins_s)
  );

  ser_ctl_frame #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_i),
    .ce        (pins_s[2]),
    .sck       (pins_s[1]),
    .sdi       (pins_s[0]),
    .stat_word (stat_word),
    .sdo       (host_sdo),
    .commit    (commit),
    .wdata     (wdata)
  );

  ser_ctl_mode #(.DW(DATA_W)) u_mode (
    .clk    (clk),
    .rst_n  (rst_i),
    .commit (commit),
    .wdata  (wdata),
    .mode   (mode),
    .analog (analog)
  );

  ser_ctl_status #(.DW(DATA_W), .CW(CAT_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_i),
    .lock_ok  (lock_ok),
    .analog   (analog),
    .st_valid (st_valid),
    .st_fs    (st_fs),
    .st_copy  (st_copy),
    .st_cs0   (st_cs0),
    .st_cat   (st_cat),
    .word     (stat_word)
  );

  assign src_sel     = mode.src;
  assign mon1_sel    = mode.mon1;
  assign mon2_sel    = mode.mon2;
  assign word20      = mode.word20;
  assign sys_stop    = mode.stop;
  assign analog_mode = analog;
endmodule

// File: tb/ser_ctl_port_test.sv
module ser_ctl_port_test;
  localparam int HALF = 6;
  localparam logic [7:0] AWR = 8'h65;
  localparam logic [7:0] ARD = 8'h66;
  localparam logic [15:0] ERRPAT = 16'h0002;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_ce = 1'b0, host_sck = 1'b0, host_sdi = 1'b0;
  logic host_sdo;
  logic lock_ok = 1'b1, st_valid = 1'b0, st_copy = 1'b0, st_cs0 = 1'b0;
  logic [1:0] st_fs = 2'b00;
  logic [7:0] st_cat = 8'h00;
  logic [2:0] src_sel, mon1_sel, mon2_sel;
  logic word20, sys_stop, analog_mode;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ser_ctl_port uut (
    .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_sck(host_sck),
    .host_sdi(host_sdi), .host_sdo(host_sdo), .lock_ok(lock_ok),
    .st_valid(st_valid), .st_fs(st_fs), .st_copy(st_copy), .st_cs0(st_cs0),
    .st_cat(st_cat), .src_sel(src_sel), .mon1_sel(mon1_sel),
    .mon2_sel(mon2_sel), .word20(word20), .sys_stop(sys_stop),
    .analog_mode(analog_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stat_exp(input logic [1:0] fs, input logic cp,
                                           input logic c0, input logic [7:0] cat);
    return {3'b000, cat, c0, cp, fs[0], fs[1], 1'b0};
  endfunction

  function automatic logic [15:0] mode_word(input logic stop, input logic [2:0] src,
      input logic [2:0] m1, input logic [2:0] m2, input logic w20);
    return {1'b1, w20, m2, m1, src, stop, 4'hF};
  endfunction

  function automatic logic [31:0] outs();
    return {20'h0, analog_mode, sys_stop, word20, mon2_sel, mon1_sel, src_sel};
  endfunction

  function automatic logic [31:0] outs_exp(input logic stop, input logic [2:0] src,
      input logic [2:0] m1, input logic [2:0] m2, input logic w20);
    return {20'h0, (src >= 3'd5), stop, w20, m2, m1, src};
  endfunction

  task automatic xfer(input logic [7:0] a, input int n, input logic [31:0] d);
    host_ce = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8 + n; i++) begin
      host_sdi = (i < 8) ? a[i] : d[i-8];
      host_sck = 1'b0;
      repeat (HALF) @(negedge clk);
      host_sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    host_sck = 1'b0;
    host_sdi = 1'b0;
    repeat (HALF) @(negedge clk);
    host_ce = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic read_expect(input string req, input logic [15:0] w, input int n);
    exp_q.push_back(w);
    tag_q.push_back(req);
    xfer(ARD, n, 32'h0);
  endtask

  task automatic strobe(input logic [1:0] fs, input logic cp, input logic c0, input logic [7:0] cat);
    st_fs = fs; st_copy = cp; st_cs0 = c0; st_cat = cat;
    @(negedge clk); st_valid = 1'b1;
    @(negedge clk); st_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: observes the serial link and compares read words with the queue
  initial begin : monitor
    logic [7:0]  ma;
    logic [23:0] md;
    int nb;
    forever begin
      @(posedge host_ce);
      ma = '0; md = '0; nb = 0;
      while (host_ce) begin
        @(posedge host_sck or negedge host_ce);
        if (host_ce) begin
          if (nb < 8) ma[nb] = host_sdi;
          else if (nb < 32) md[nb-8] = host_sdo;
          nb++;
        end
      end
      if (ma == ARD && nb >= 24) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 actual %h expected none (no queued item)", md);
        end else begin
          check(tag_q.pop_front(), {8'h0, md}, {16'h0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 outputs", outs(), 32'h0);
    check("R1 sdo", {31'h0, host_sdo}, 32'h0);

    // R9 before any strobe, locked: error pattern
    read_expect("R9 pre-strobe", ERRPAT, 16);

    // R6 status layout, two patterns
    strobe(2'b01, 1'b1, 1'b1, 8'hA5);
    read_expect("R6 pattern A", stat_exp(2'b01, 1'b1, 1'b1, 8'hA5), 16);
    strobe(2'b11, 1'b0, 1'b1, 8'h3C);
    read_expect("R6 pattern B", stat_exp(2'b11, 1'b0, 1'b1, 8'h3C), 16);
    // R10 extra clocks read zero
    read_expect("R10 trailing", stat_exp(2'b11, 1'b0, 1'b1, 8'h3C), 20);

    // R2 write decode
    xfer(AWR, 16, {16'h0, mode_word(1'b1, 3'd3, 3'd6, 3'd5, 1'b1)});
    check("R2 write A", outs(), outs_exp(1'b1, 3'd3, 3'd6, 3'd5, 1'b1));
    xfer(AWR, 16, {16'h0, mode_word(1'b0, 3'd1, 3'd2, 3'd4, 1'b0)});
    check("R2 write B", outs(), outs_exp(1'b0, 3'd1, 3'd2, 3'd4, 1'b0));

    // R4 wrong address and read address with data
    xfer(8'h64, 16, {16'h0, mode_word(1'b1, 3'd7, 3'd7, 3'd7, 1'b1)});
    check("R4 bad address", outs(), outs_exp(1'b0, 3'd1, 3'd2, 3'd4, 1'b0));
    read_expect("R4 read addr", stat_exp(2'b11, 1'b0, 1'b1, 8'h3C), 16);
    check("R4 read addr no write", outs(), outs_exp(1'b0, 3'd1, 3'd2, 3'd4, 1'b0));

    // R5 wrong lengths
    xfer(AWR, 15, {16'h0, mode_word(1'b1, 3'd2, 3'd3, 3'd1, 1'b1)});
    check("R5 15 bits", outs(), outs_exp(1'b0, 3'd1, 3'd2, 3'd4, 1'b0));
    xfer(AWR, 17, {15'h0, mode_word(1'b1, 3'd2, 3'd3, 3'd1, 1'b1), 1'b0});
    check("R5 17 bits", outs(), outs_exp(1'b0, 3'd1, 3'd2, 3'd4, 1'b0));

    // R7 lock loss forces pattern, stays until fresh strobe
    lock_ok = 1'b0;
    repeat (3) @(negedge clk);
    read_expect("R7 lock lost", ERRPAT, 16);
    lock_ok = 1'b1;
    repeat (3) @(negedge clk);
    read_expect("R7 relock no strobe", ERRPAT, 16);
    strobe(2'b00, 1'b1, 1'b0, 8'h81);
    read_expect("R7 relock strobe", stat_exp(2'b00, 1'b1, 1'b0, 8'h81), 16);

    // R3 / R8 analog codes
    for (int c = 4; c < 8; c++) begin
      xfer(AWR, 16, {16'h0, mode_word(1'b0, 3'(c), 3'd0, 3'd0, 1'b0)});
      check("R3 analog decode", outs(), outs_exp(1'b0, 3'(c), 3'd0, 3'd0, 1'b0));
      strobe(2'b01, 1'b1, 1'b1, 8'hF0);
      if (c >= 5) read_expect("R8 analog forced", ERRPAT, 16);
      else        read_expect("R8 digital source", stat_exp(2'b01, 1'b1, 1'b1, 8'hF0), 16);
    end

    repeat (10) @(negedge clk);
    check("R6 queue drained", exp_q.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule